// File: doc/BRIEF.md
# UART Frame Transmitter

This block turns one data word into an asynchronous serial frame on a single output line. A write strobe loads a 9-bit holding register. When transmission is enabled and the holding register holds unsent data, the block copies the word into a shift register and sends a frame. A frame is one low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit lasts a fixed number of baud ticks, and those ticks come from an external rate generator.

Three control inputs set the frame format: a two-bit word-length code, a parity enable with an odd/even select, and a two-bit stop code. The block samples them when a frame starts. Two flags report progress. `hold_empty` is high when the holding register has nothing left to send. `tx_done` is high when the line has finished a frame and is idle.

The controller has five states:

| State | Meaning |
|---|---|
| `ST_IDLE` | The line is held high. |
| `ST_START` | The start bit is on the line. |
| `ST_DATA` | Data bits are being shifted out. |
| `ST_PARITY` | The parity bit is on the line. |
| `ST_STOP` | The stop bits are on the line. |

The transitions are:

- `ST_IDLE` to `ST_START` when `tx_en` is high and `hold_empty` is low.
- `ST_START` to `ST_DATA` at the end of the start bit.
- `ST_DATA` stays in `ST_DATA` until the last payload bit ends.
- `ST_DATA` to `ST_PARITY` when parity is enabled.
- `ST_DATA` to `ST_STOP` when parity is disabled.
- `ST_PARITY` to `ST_STOP` at the end of the parity bit.
- `ST_STOP` stays in `ST_STOP` for the second stop bit.
- `ST_STOP` to `ST_IDLE` at the end of the last stop bit.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `tx_out` is 1, `hold_empty` is 1 and `tx_done` is 1.
- R2: A cycle with `wr_stb` high loads `wr_data` into the holding register and makes `hold_empty` 0 on the next cycle, whatever state the block is in.
- R3: A frame starts only when `tx_en` is 1 and `hold_empty` is 0. While `tx_en` is 0, the line stays high and `tx_done` stays 1. When a frame starts, `tx_done` falls and the line goes low for the start bit in the same cycle.
- R4: The line idles at 1. A frame is a start bit of 0, then data bits least significant bit first, then stop bits of 1. Every bit lasts 16 baud ticks.
- R5: The word-length code `word_len` gives the frame size before parity: 2'b00 gives 8 bits, 2'b01 gives 9 bits, 2'b10 gives 7 bits, and 2'b11 gives 8 bits. Data bits above the frame size are not sent.
- R6: When `par_en` is 1, the parity bit takes the place of the last bit of the frame size, so one fewer data bit is sent. With `par_odd` at 1, the sent data bits plus the parity bit hold an odd number of ones. With `par_odd` at 0, they hold an even number.
- R7: Stop code `stop_sel` = 2'b10 sends two stop bits. Codes 2'b00, 2'b01 and 2'b11 each send one.
- R8: At the end of the last stop bit, `tx_done` and `hold_empty` both become 1 in the same cycle, provided no write arrived during the frame.
- R9: A write during a frame does not change the frame being sent. At that frame's end, `hold_empty` stays 0 and the new word is sent as the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Holding register write strobe |
| wr_data | input | 9 | Word to transmit |
| tx_en | input | 1 | Transmission enable |
| word_len | input | 2 | Word-length code |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_sel | input | 2 | Stop-bit code |
| baud_tick | input | 1 | One-cycle pulse from the rate generator |
| tx_out | output | 1 | Serial line |
| hold_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Frame complete and line idle |

## Verification
The assertions check several rules on every cycle:

- A write always clears `hold_empty` on the next cycle.
- The line is high whenever `tx_done` is set.
- `tx_done` falls only as the start bit appears.
- `tx_done` stays set while transmission is disabled or nothing is pending.
- When `tx_done` rises, `hold_empty` rises with it unless a write arrived during the frame.

Some behaviour only the directed scenarios can show, because it depends on the bit sequence and the tick count:

- the bit order, least significant first;
- the frame size for each word-length code;
- the parity value;
- the number of stop bits;
- the intact frame after a write during that frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    localparam logic [1:0] STOP_CODE_TWO = 2'b10;

endpackage

// File: rtl/uart_tx_fmt.sv
// Frame format decode: number of payload bits, parity value, stop count.
module uart_tx_fmt #(
    parameter int DATA_W = 9,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        stop_sel,
    output logic [CNT_W-1:0]  payload_bits,
    output logic              par_bit,
    output logic              two_stop
);
    import uart_tx_pkg::*;

    logic [CNT_W-1:0] frame_bits;
    logic             acc;

    always_comb begin
        unique case (word_len)
            2'b01:   frame_bits = CNT_W'(9);
            2'b10:   frame_bits = CNT_W'(7);
            default: frame_bits = CNT_W'(8);
        endcase
        payload_bits = frame_bits - CNT_W'(par_en);
        acc = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(payload_bits)) acc = acc ^ data[i];
        end
        par_bit = acc ^ par_odd;
    end

    assign two_stop = (stop_sel == STOP_CODE_TWO);

endmodule

// File: rtl/uart_tx_bitclk.sv
// Counts baud ticks within one bit; flags the tick that closes the bit.
module uart_tx_bitclk #(
    parameter int TICKS_PER_BIT = 16,
    localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic baud_tick,
    output logic bit_end
);
    logic [TW-1:0] tick_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt_q <= '0;
        end else if (clear) begin
            tick_cnt_q <= '0;
        end else if (baud_tick) begin
            if (tick_cnt_q == TW'(TICKS_PER_BIT - 1)) tick_cnt_q <= '0;
            else                                      tick_cnt_q <= tick_cnt_q + TW'(1);
        end
    end

    assign bit_end = baud_tick && !clear && (tick_cnt_q == TW'(TICKS_PER_BIT - 1));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
    parameter int DATA_W        = 9,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_en,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        stop_sel,
    input  logic              baud_tick,
    output logic              tx_out,
    output logic              hold_empty,
    output logic              tx_done
);
    import uart_tx_pkg::*;

    localparam int CNT_W = $clog2(DATA_W + 1);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] hold_q, shift_q;
    logic [CNT_W-1:0]  bits_left_q;
    logic              par_en_q, par_bit_q, two_stop_q, stop_idx_q;
    logic              hold_empty_q, tx_done_q, refill_q;

    logic [CNT_W-1:0]  payload_bits;
    logic              par_bit, two_stop;
    logic              bit_end, go, frame_end, busy;

    uart_tx_fmt #(.DATA_W(DATA_W)) u_fmt (
        .data         (hold_q),
        .word_len     (word_len),
        .par_en       (par_en),
        .par_odd      (par_odd),
        .stop_sel     (stop_sel),
        .payload_bits (payload_bits),
        .par_bit      (par_bit),
        .two_stop     (two_stop)
    );

    uart_tx_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_q == ST_IDLE),
        .baud_tick (baud_tick),
        .bit_end   (bit_end)
    );

    assign busy      = (state_q != ST_IDLE);
    assign go        = (state_q == ST_IDLE) && tx_en && !hold_empty_q;
    assign frame_end = (state_q == ST_STOP) && bit_end && (stop_idx_q || !two_stop_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go) state_d = ST_START;
            ST_START:  if (bit_end) state_d = ST_DATA;
            ST_DATA:   if (bit_end && bits_left_q == '0)
                           state_d = par_en_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end) state_d = ST_STOP;
            ST_STOP:   if (frame_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            hold_q       <= '0;
            shift_q      <= '0;
            bits_left_q  <= '0;
            par_en_q     <= 1'b0;
            par_bit_q    <= 1'b0;
            two_stop_q   <= 1'b0;
            stop_idx_q   <= 1'b0;
            hold_empty_q <= 1'b1;
            tx_done_q    <= 1'b1;
            refill_q     <= 1'b0;
        end else begin
            state_q <= state_d;

            if (go) begin
                shift_q     <= hold_q;
                bits_left_q <= payload_bits - CNT_W'(1);
                par_en_q    <= par_en;
                par_bit_q   <= par_bit;
                two_stop_q  <= two_stop;
                stop_idx_q  <= 1'b0;
            end else if (state_q == ST_DATA && bit_end) begin
                shift_q <= shift_q >> 1;
                if (bits_left_q != '0) bits_left_q <= bits_left_q - CNT_W'(1);
            end else if (state_q == ST_STOP && bit_end) begin
                stop_idx_q <= 1'b1;
            end

            if (wr_stb) hold_q <= wr_data;

            if (wr_stb && (busy || go)) refill_q <= 1'b1;
            else if (go)                refill_q <= 1'b0;

            if (wr_stb)                      hold_empty_q <= 1'b0;
            else if (frame_end && !refill_q) hold_empty_q <= 1'b1;

            if (go)             tx_done_q <= 1'b0;
            else if (frame_end) tx_done_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_START:  tx_out = 1'b0;
            ST_DATA:   tx_out = shift_q[0];
            ST_PARITY: tx_out = par_bit_q;
            default:   tx_out = 1'b1;
        endcase
    end

    assign hold_empty = hold_empty_q;
    assign tx_done    = tx_done_q;

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_stb,
    input logic tx_en,
    input logic tx_out,
    input logic hold_empty,
    input logic tx_done
);
    logic wrote_in_frame_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 wrote_in_frame_q <= 1'b0;
        else if ($fell(tx_done))    wrote_in_frame_q <= wr_stb;
        else if (wr_stb && !tx_done) wrote_in_frame_q <= 1'b1;
    end

    // R2
    write_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !hold_empty);

    // R4
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> tx_out);

    // R3
    start_bit_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_done) |-> !tx_out);

    // R3
    disabled_stays_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !tx_en) |=> tx_done);

    // R3
    nothing_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && hold_empty) |=> tx_done);

    // R8
    flags_rise_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_done) && !wrote_in_frame_q && !$past(wr_stb)) |-> hold_empty);

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .tx_en      (tx_en),
    .tx_out     (tx_out),
    .hold_empty (hold_empty),
    .tx_done    (tx_done)
);

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/1ps
module uart_frame_tx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tx_en = 1'b0;
    logic [1:0] word_len = 2'b00;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [1:0] stop_sel = 2'b00;
    logic       baud_tick = 1'b0;
    logic       tx_out, hold_empty, tx_done;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    uart_frame_tx u_dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .tx_en(tx_en), .word_len(word_len), .par_en(par_en), .par_odd(par_odd),
        .stop_sel(stop_sel), .baud_tick(baud_tick), .tx_out(tx_out),
        .hold_empty(hold_empty), .tx_done(tx_done)
    );

    // baud tick every 4 clocks, driven at the falling edge
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            baud_tick = (cnt == 3);
            cnt = (cnt + 1) % 4;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int k;
        k = 0;
        while (k < n) begin
            @(posedge clk);
            if (baud_tick) k++;
        end
        @(negedge clk);
    endtask

    task automatic write_word(input logic [8:0] d);
        @(negedge clk);
        wr_stb = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_start(input string req);
        int n;
        n = 0;
        while (tx_out !== 1'b0 && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk(tx_out === 1'b0, req, tx_out, 0);
    endtask

    // Samples one frame from its start bit; optionally writes a new word
    // right after the start bit appears.
    task automatic capture(input logic [8:0] d, input logic inject,
                           input logic [8:0] inj, input string req);
        int frame_bits, pay, nstop;
        logic p;
        frame_bits = (word_len == 2'b01) ? 9 : (word_len == 2'b10) ? 7 : 8;
        pay = frame_bits - int'(par_en);
        p = par_odd;
        for (int i = 0; i < pay; i++) p = p ^ d[i];
        nstop = (stop_sel == 2'b10) ? 2 : 1;

        wait_start({req, " start"});
        chk(tx_done == 1'b0, "R3 tx_done low in frame", tx_done, 0);
        if (inject) begin
            write_word(inj);
            chk(hold_empty == 1'b0, "R9 write in frame clears hold_empty", hold_empty, 0);
            wait_ticks(7);
        end else begin
            wait_ticks(8);
        end
        chk(tx_out == 1'b0, "R4 start bit low", tx_out, 0);
        for (int i = 0; i < pay; i++) begin
            wait_ticks(16);
            chk(tx_out == d[i], {req, " data bit"}, tx_out, d[i]);
        end
        if (par_en) begin
            wait_ticks(16);
            chk(tx_out == p, "R6 parity bit", tx_out, p);
        end
        for (int s = 0; s < nstop; s++) begin
            wait_ticks(16);
            chk(tx_out == 1'b1 && tx_done == 1'b0, "R7 stop bit high and frame busy",
                {tx_out, tx_done}, 2);
        end
    endtask

    task automatic check_end(input string req);
        wait_ticks(16);
        chk(tx_done == 1'b1 && hold_empty == 1'b1 && tx_out == 1'b1, req,
            {tx_done, hold_empty, tx_out}, 7);
    endtask

    task automatic run_frame(input logic [8:0] d, input logic [1:0] wl, input logic pe,
                             input logic po, input logic [1:0] st, input string req);
        word_len = wl; par_en = pe; par_odd = po; stop_sel = st; tx_en = 1'b1;
        write_word(d);
        capture(d, 1'b0, '0, req);
        check_end("R8 flags set at frame end");
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk(tx_out == 1'b1, "R1 tx_out after reset", tx_out, 1);
        chk(hold_empty == 1'b1, "R1 hold_empty after reset", hold_empty, 1);
        chk(tx_done == 1'b1, "R1 tx_done after reset", tx_done, 1);
    endtask

    task automatic test_disabled();
        tx_en = 1'b0; word_len = 2'b00; par_en = 1'b0; stop_sel = 2'b00;
        write_word(9'h055);
        chk(hold_empty == 1'b0, "R2 write clears hold_empty", hold_empty, 0);
        wait_ticks(100);
        chk(tx_out == 1'b1 && tx_done == 1'b1, "R3 no frame while disabled",
            {tx_out, tx_done}, 3);
        tx_en = 1'b1;
        capture(9'h055, 1'b0, '0, "R3 frame after enable");
        check_end("R8 flags set at frame end");
    endtask

    task automatic test_midframe_write();
        word_len = 2'b00; par_en = 1'b0; stop_sel = 2'b00; tx_en = 1'b1;
        write_word(9'h03C);
        capture(9'h03C, 1'b1, 9'h0C3, "R9 first frame intact");
        capture(9'h0C3, 1'b0, '0, "R9 second frame");
        check_end("R8 flags after second frame");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_frame(9'h0A5, 2'b00, 1'b0, 1'b0, 2'b00, "R4 8-bit frame");
        run_frame(9'h1C3, 2'b01, 1'b0, 1'b0, 2'b00, "R5 9-bit frame");
        run_frame(9'h1FF, 2'b10, 1'b0, 1'b0, 2'b01, "R5 7-bit frame");
        run_frame(9'h181, 2'b11, 1'b0, 1'b0, 2'b11, "R5 code 11 as 8-bit");
        run_frame(9'h0B3, 2'b00, 1'b1, 1'b0, 2'b00, "R6 even parity frame");
        run_frame(9'h0B3, 2'b01, 1'b1, 1'b1, 2'b00, "R6 odd parity frame");
        run_frame(9'h05A, 2'b10, 1'b1, 1'b1, 2'b10, "R7 two stop frame");
        test_disabled();
        test_midframe_write();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule